// File: doc/BRIEF.md
# MDIO Management Register Slave

This block sits on the PHY side of a two-wire serial management link. A host moves a clock line and a data line by writing them as register bits, and the block samples both on its own system clock. Every low-to-high step of the management clock shifts the host's data bit into a 32-bit sliding window. The block decodes frames from that window: a run of 32 ones, a start pair, an opcode, a PHY address, a register address, a turnaround pair and 16 data bits. It writes into a bank of 32 sixteen-bit registers, or reads from it.

A read returns the addressed register on the data-in line, most significant bit first. A write stores the last 16 bits of the frame. A frame with the wrong PHY address or an unsupported opcode is dropped. After any frame, including a dropped one, the block will not accept a new start pair until it sees 32 more ones. Reset loads fixed default values into the register bank.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After reset the data-in output is 1. Register 0 reads 0x3000, register 1 reads 0x782D, register 4 reads 0x05E1, and every other register reads 0x0000.
- R2: A management-clock rising edge is a system-clock cycle in which the clock input is 1 and was 0 in the cycle before. Each such edge shifts exactly one host bit. Holding the clock high for many cycles shifts nothing more.
- R3: After reset, and after any frame ends or is dropped, a start pair is accepted only after at least 32 consecutive 1 bits. A frame with only 31 leading ones has no effect.
- R4: After the ones, a frame is: the start pair 0 then 1, two opcode bits, five PHY address bits, five register address bits, two turnaround bits and 16 data bits. All fields are sent MSB first. Opcode 01 is a write and opcode 10 is a read.
- R5: A frame whose PHY address differs from the PHY_ADDR parameter (default 0) is dropped, and no register changes.
- R6: A frame with opcode 00 or 11 is dropped, and no register changes.
- R7: A write stores its 16 data bits into the addressed register on the 16th data edge.
- R8: On a read, data-in goes to 0 after the second turnaround edge. It then shows register bits 15 down to 0, one per edge, after each of the next 16 edges. It returns to 1 once every bit still to be sent is 1, and no later than the 17th edge.
- R9: Outside a read, data-in is held at 1.
- R10: The host output-enable input has no effect on decoding, writes or reads.
- R11: All 32 registers can be written, and each one holds its own value. A write to one register leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_clk_i | input | 1 | Management clock level written by the host |
| mgmt_dout_i | input | 1 | Data bit driven by the host |
| mgmt_oe_i | input | 1 | Host output-enable level (not used for decoding) |
| mgmt_din_o | output | 1 | Data bit sampled by the host |

## Verification
A wrong frame state shows up on the next read frame. Data-in either fails to drop low after the second turnaround edge or shows shifted register bits, so a read-back exposes it within one frame of about 66 management edges. A bad decode of the address or opcode, or a wrong acceptance, corrupts a register without any sign at the time. It is only found by the read that follows, so every write and every dropped frame in the bench is followed by a read of the same register. A window that never counts 32 ones leaves the block deaf, and the very next read then returns all ones.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int WIN_W    = 32;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 5;
    localparam int OP_W     = 2;
    localparam int REG_NUM  = 1 << ADDR_W;
    localparam int HDR_W    = OP_W + 2 * ADDR_W;
    localparam int HDR_LSB  = 2;
    localparam int TAIL_W   = DATA_W + 1;

    localparam logic [WIN_W-1:0] WIN_ONES  = '1;
    localparam logic [WIN_W-1:0] START_WIN = 32'hFFFF_FFFD;
    localparam logic [WIN_W-1:0] HDR_MASK  = 32'hFFFF_C000;
    localparam logic [WIN_W-1:0] HDR_MATCH = 32'hFFFF_4000;

    localparam logic [OP_W-1:0] OP_WR = 2'b01;
    localparam logic [OP_W-1:0] OP_RD = 2'b10;

    typedef enum logic [2:0] {
        ST_WAIT_IDLE,
        ST_IDLE,
        ST_GOT_START,
        ST_READ,
        ST_WRITE
    } frame_state_e;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] addr;
    } frame_hdr_t;

    function automatic frame_hdr_t hdr_unpack(input logic [HDR_W-1:0] bits);
        frame_hdr_t h;
        h = bits;
        return h;
    endfunction

    function automatic logic [DATA_W-1:0] reg_reset_value(input int unsigned idx);
        case (idx)
            0:       return 16'h3000;
            1:       return 16'h782D;
            4:       return 16'h05E1;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/mdio_edge_sense.sv
module mdio_edge_sense (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic rise_o
);
    logic line_q;

    always_ff @(posedge clk) begin
        if (rst) line_q <= 1'b0;
        else     line_q <= line_i;
    end

    assign rise_o = line_i & ~line_q;

    AST_NO_BACK_TO_BACK_RISE: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o); // R2

endmodule

// File: rtl/mdio_reg_array.sv
module mdio_reg_array
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [DATA_W-1:0] mem [REG_NUM];

    always_ff @(posedge clk) begin
        for (int i = 0; i < REG_NUM; i++) begin
            if (rst)
                mem[i] <= reg_reset_value(i);
            else if (wr_en_i && (wr_addr_i == ADDR_W'(i)))
                mem[i] <= wr_data_i;
        end
    end

    assign rd_data_o = mem[rd_addr_i];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> mem[$past(wr_addr_i)] == $past(wr_data_i)); // R7

endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
    import mdio_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PHY_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_i,
    input  logic              bit_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              din_o
);
    frame_state_e      state_q, state_d;
    logic [WIN_W-1:0]  win_q, win_d, win_nx, win_rd;
    logic [ADDR_W-1:0] reg_q, reg_d;
    logic              din_q, din_d;
    frame_hdr_t        hdr;

    assign win_nx    = {win_q[WIN_W-2:0], bit_i};
    assign win_rd    = {win_q[WIN_W-2:0], 1'b1};
    assign hdr       = hdr_unpack(win_nx[HDR_LSB +: HDR_W]);
    assign rd_addr_o = hdr.addr;
    assign wr_addr_o = reg_q;
    assign wr_data_o = win_nx[DATA_W-1:0];
    assign din_o     = din_q;

    always_comb begin
        state_d = state_q;
        win_d   = win_q;
        reg_d   = reg_q;
        din_d   = din_q;
        wr_en_o = 1'b0;
        if (rise_i) begin
            win_d = win_nx;
            din_d = 1'b1;
            case (state_q)
                ST_WAIT_IDLE: if (win_nx == WIN_ONES)  state_d = ST_IDLE;
                ST_IDLE:      if (win_nx == START_WIN) state_d = ST_GOT_START;
                ST_GOT_START: begin
                    if ((win_nx & HDR_MASK) == HDR_MATCH) begin
                        reg_d = hdr.addr;
                        if (hdr.phy != PHY_ADDR) begin
                            state_d = ST_WAIT_IDLE;
                        end else if (hdr.op == OP_WR) begin
                            state_d = ST_WRITE;
                        end else if (hdr.op == OP_RD) begin
                            win_d   = {{(WIN_W-DATA_W){1'b0}}, rd_data_i};
                            din_d   = 1'b0;
                            state_d = ST_READ;
                        end else begin
                            state_d = ST_WAIT_IDLE;
                        end
                    end
                end
                ST_WRITE: begin
                    if (win_nx[WIN_W-1 -: 2] == 2'b01) begin
                        wr_en_o = 1'b1;
                        state_d = ST_WAIT_IDLE;
                    end
                end
                ST_READ: begin
                    win_d = win_rd;
                    if (&win_rd[TAIL_W-1:0]) begin
                        state_d = ST_WAIT_IDLE;
                    end else begin
                        din_d = win_rd[DATA_W];
                    end
                end
                default: state_d = ST_WAIT_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT_IDLE;
            win_q   <= '0;
            reg_q   <= '0;
            din_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            win_q   <= win_d;
            reg_q   <= reg_d;
            din_q   <= din_d;
        end
    end

    AST_DIN_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_READ) |-> din_q); // R9
    AST_HOLD_WITHOUT_RISE: assert property (@(posedge clk) disable iff (rst)
        !rise_i |=> $stable(win_q) && $stable(state_q)); // R2
    AST_IDLE_NEEDS_ONES: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && $past(state_q) == ST_WAIT_IDLE) |-> win_q == WIN_ONES); // R3
    AST_START_PATTERN: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GOT_START && $past(state_q) == ST_IDLE) |-> win_q == START_WIN); // R4
    AST_WRITE_HDR_OK: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WRITE && $past(state_q) == ST_GOT_START)
            |-> (win_q[11:7] == PHY_ADDR && win_q[13:12] == OP_WR)); // R5
    AST_TURNAROUND_LOW: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_READ && $past(state_q) == ST_GOT_START) |-> !din_q); // R8
    AST_WRITE_ONLY_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> state_q == ST_WRITE); // R6

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
    import mdio_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PHY_ADDR = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic mgmt_clk_i,
    input  logic mgmt_dout_i,
    input  logic mgmt_oe_i,
    output logic mgmt_din_o
);
    logic              rise;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic              unused_oe;

    // R10: the enable level plays no part in framing
    assign unused_oe = mgmt_oe_i;

    mdio_edge_sense u_edge (
        .clk    (clk),
        .rst    (rst),
        .line_i (mgmt_clk_i),
        .rise_o (rise)
    );

    mdio_frame_ctrl #(.PHY_ADDR(PHY_ADDR)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .rise_i    (rise),
        .bit_i     (mgmt_dout_i),
        .rd_data_i (rd_data),
        .rd_addr_o (rd_addr),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .din_o     (mgmt_din_o)
    );

    mdio_reg_array u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

endmodule

// File: tb/mdio_mgmt_slave_test.sv
module mdio_mgmt_slave_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mclk = 1'b0;
    logic mdo = 1'b1;
    logic moe = 1'b0;
    logic din;

    int n_chk = 0;
    int n_bad = 0;
    int half_cyc = 2;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mdio_mgmt_slave uut (
        .clk         (clk),
        .rst         (rst),
        .mgmt_clk_i  (mclk),
        .mgmt_dout_i (mdo),
        .mgmt_oe_i   (moe),
        .mgmt_din_o  (din)
    );

    // {op[1:0], phy[4:0], reg[4:0], data_or_expected[15:0]}; op 10 = read
    localparam int NVEC = 22;
    localparam logic [27:0] VEC [NVEC] = '{
        {2'b10, 5'd0, 5'd0,  16'h3000},  // R1 default
        {2'b10, 5'd0, 5'd1,  16'h782D},  // R1
        {2'b10, 5'd0, 5'd4,  16'h05E1},  // R1
        {2'b10, 5'd0, 5'd2,  16'h0000},  // R1
        {2'b10, 5'd0, 5'd20, 16'h0000},  // R1
        {2'b01, 5'd0, 5'd2,  16'hA5C3},  // R7 write
        {2'b10, 5'd0, 5'd2,  16'hA5C3},  // R7 read back
        {2'b01, 5'd0, 5'd31, 16'h8001},  // R11
        {2'b10, 5'd0, 5'd31, 16'h8001},  // R11
        {2'b10, 5'd0, 5'd0,  16'h3000},  // R11 neighbour untouched
        {2'b01, 5'd3, 5'd2,  16'hFFFF},  // R5 wrong PHY
        {2'b10, 5'd0, 5'd2,  16'hA5C3},  // R5
        {2'b00, 5'd0, 5'd2,  16'h1234},  // R6 opcode 00
        {2'b10, 5'd0, 5'd2,  16'hA5C3},  // R6
        {2'b11, 5'd0, 5'd2,  16'h4321},  // R6 opcode 11
        {2'b10, 5'd0, 5'd2,  16'hA5C3},  // R6
        {2'b01, 5'd0, 5'd7,  16'hFFFF},  // R8 early release
        {2'b10, 5'd0, 5'd7,  16'hFFFF},  // R8
        {2'b01, 5'd0, 5'd8,  16'h0001},  // R8 lsb only
        {2'b10, 5'd0, 5'd8,  16'h0001},  // R8
        {2'b01, 5'd0, 5'd1,  16'h7FFE},  // R11 status writable
        {2'b10, 5'd0, 5'd1,  16'h7FFE}   // R8 ones run inside data
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic mbit(input logic b, input logic oe);
        @(negedge clk);
        mclk = 1'b0; mdo = b; moe = oe;
        repeat (half_cyc - 1) @(negedge clk);
        @(negedge clk);
        mclk = 1'b1;
        repeat (half_cyc) @(negedge clk);
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] adr,
                            input int pre, input logic oe);
        for (int i = 0; i < pre; i++) mbit(1'b1, oe);
        mbit(1'b0, oe); mbit(1'b1, oe);
        for (int i = 1; i >= 0; i--) mbit(op[i], oe);
        for (int i = 4; i >= 0; i--) mbit(phy[i], oe);
        for (int i = 4; i >= 0; i--) mbit(adr[i], oe);
    endtask

    task automatic write_frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] adr,
                               input logic [15:0] data, input int pre, input logic oe);
        logic low_seen;
        send_hdr(op, phy, adr, pre, oe);
        low_seen = 1'b0;
        mbit(1'b1, oe); low_seen |= !din;
        mbit(1'b0, oe); low_seen |= !din;
        for (int i = 15; i >= 0; i--) begin
            mbit(data[i], oe);
            low_seen |= !din;
        end
        check("R9 data-in high during non-read frame", {15'd0, low_seen}, 16'd0);
    endtask

    task automatic read_frame(input logic [4:0] adr, input logic [15:0] exp, input logic oe);
        logic [15:0] got;
        send_hdr(2'b10, 5'd0, adr, 32, oe);
        mbit(1'b1, oe);
        mbit(1'b1, oe);
        check("R8 turnaround low", {15'd0, din}, 16'd0);
        for (int i = 15; i >= 0; i--) begin
            mbit(1'b1, !oe);
            got[i] = din;
        end
        check("R8 read data", got, exp);
        mbit(1'b1, oe);
        check("R8 release after read", {15'd0, din}, 16'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 data-in after reset", {15'd0, din}, 16'd1);

        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][27:26] == 2'b10)
                read_frame(VEC[v][20:16], VEC[v][15:0], 1'b1);
            else
                write_frame(VEC[v][27:26], VEC[v][25:21], VEC[v][20:16], VEC[v][15:0], 32, 1'b1);
        end

        // R3: zero data leaves no ones run; then 31 ones are not enough
        write_frame(2'b01, 5'd0, 5'd10, 16'h0000, 32, 1'b1);
        write_frame(2'b01, 5'd0, 5'd9, 16'h1111, 31, 1'b1);
        read_frame(5'd9, 16'h0000, 1'b1);   // R3 short preamble ignored
        read_frame(5'd10, 16'h0000, 1'b1);  // R3

        // R10: enable levels inverted against normal use
        write_frame(2'b01, 5'd0, 5'd12, 16'h5A5A, 32, 1'b0);
        read_frame(5'd12, 16'h5A5A, 1'b0);  // R10

        // R2: management clock held high for several system cycles
        half_cyc = 7;
        write_frame(2'b01, 5'd0, 5'd13, 16'hC3A4, 32, 1'b1);
        read_frame(5'd13, 16'hC3A4, 1'b1);  // R2
        half_cyc = 2;

        // R4: register address field MSB first
        write_frame(2'b01, 5'd0, 5'd16, 16'h0F0F, 32, 1'b1);
        read_frame(5'd1, 16'h7FFE, 1'b1);   // R4 reg 1 not hit by reg 16
        read_frame(5'd16, 16'h0F0F, 1'b1);  // R4

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule